// File: doc/BRIEF.md
# Dual Lock-Step Channel Mode Controller

This block sits between four processing cores, arranged as two self-checking channels, and the outputs of the system. Each channel is a master/checker pair. The pair's own comparator raises a mismatch flag whenever master and checker disagree. The controller decides, cycle by cycle, which channel results may be committed to the output ports, and which channels are still trusted.

In lock-step mode both channels run the same code. Their results are compared against each other before anything is committed. Channel A drives output port 0 while it is healthy. When A reports a mismatch, B takes over in the same cycle, so a single faulty core is masked. In parallel mode the channels are independent fail-silent units. Channel A drives port 0 and channel B drives port 1, with no cross-comparison, which doubles throughput.

A channel that reports a mismatch is excluded until reset. When both channels are lost, every port goes silent and a fatal flag is raised. The operating mode is sampled during reset. Afterwards a new mode is taken only in a cycle where neither channel presents a result.

Top module: `duo_lockstep_ctrl`

## Requirements
- R1: While `rst_n` is low, the block clears all state. After release, both `p*_vld` are 0, `xdis` and `src_b` are 0, `ch_ok` is 2'b11, `fatal` is 0, and `mode_now` equals the `mode_sel` value held during reset (0 = lock-step, 1 = parallel).
- R2: In lock-step mode, with both channels healthy, equal valid bits and, when valid, equal data, the next cycle shows `p0_vld` = `a_vld` and `p0_dat` = `a_dat`. `p1_vld` is always 0 in lock-step mode.
- R3: In lock-step mode, with both channels healthy, a disagreement is defined as `a_vld` != `b_vld`, or both valid with `a_dat` != `b_dat`. On a disagreement, nothing is committed on either port and `xdis` is 1 in the next cycle. Health is left unchanged.
- R4: A mismatch flag (`a_mis` for A, `b_mis` for B) excludes that channel's result in the same cycle. The channel's `ch_ok` bit (bit 0 = A, bit 1 = B) is 0 from the next cycle on, and stays 0 until reset.
- R5: In lock-step mode, when A is excluded and B is healthy, the next cycle shows `p0_vld` = `b_vld`, `p0_dat` = `b_dat` and `src_b` = 1. No cross-check is made in this case. If only B is excluded, A is committed and `src_b` is 0.
- R6: In parallel mode, port 0 carries A's valid and data, and port 1 carries B's valid and data, one cycle later. The two ports are independent and `xdis` stays 0.
- R7: In parallel mode, the port of an excluded channel is silent, while the other port carries on.
- R8: When both channels are excluded, `fatal` is 1 and both ports are silent in every mode until reset.
- R9: A `mode_sel` value different from `mode_now` is adopted at the next edge only if `a_vld` and `b_vld` are both 0 in that cycle. Otherwise `mode_now` holds.
- R10: A port whose valid bit is 0 carries all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Requested mode: 0 lock-step, 1 parallel |
| a_vld | input | 1 | Channel A result valid |
| a_dat | input | DW | Channel A result data |
| a_mis | input | 1 | Channel A master/checker mismatch |
| b_vld | input | 1 | Channel B result valid |
| b_dat | input | DW | Channel B result data |
| b_mis | input | 1 | Channel B master/checker mismatch |
| p0_vld | output | 1 | Port 0 commit strobe |
| p0_dat | output | DW | Port 0 data |
| p1_vld | output | 1 | Port 1 commit strobe (parallel mode only) |
| p1_dat | output | DW | Port 1 data |
| xdis | output | 1 | Cross-channel disagreement in lock-step mode |
| src_b | output | 1 | Port 0 is being fed from channel B in lock-step mode |
| ch_ok | output | 2 | Per-channel health, bit 0 = A, bit 1 = B |
| fatal | output | 1 | Both channels lost |
| mode_now | output | 1 | Mode in force: 0 lock-step, 1 parallel |

## Verification
The assertions assume the following about the inputs:
- Reset is held for at least one edge before it is released.
- The inputs are steady around the rising edge.
- A mismatch flag may arrive in any cycle, together with a valid result or without one.

The stimulus changes inputs only one nanosecond after an edge and holds reset for two edges. It sweeps every valid combination and every data pair of a four-bit configuration in both modes. It then injects mismatch flags on A alone, on B alone, and on both in the same cycle. Mode requests are presented both during traffic and in idle cycles.

// File: rtl/dlc_pkg.sv
// Shared definitions for the dual lock-step channel controller.
// Assumes exactly two channels, A at index 0 and B at index 1.
package dlc_pkg;
    typedef enum logic {
        MODE_LOCK = 1'b0,
        MODE_PAR  = 1'b1
    } run_mode_e;

    localparam int NCH = 2;
endpackage

// File: rtl/dlc_health.sv
// Per-channel health tracker. A mismatch flag latches a sticky failure that
// only reset clears. The live output also drops in the very cycle of the
// mismatch, so that the failing result is never committed.
// Assumes mis is synchronous to clk.
module dlc_health (
    input  logic clk,
    input  logic rst_n,
    input  logic mis,
    output logic ok,
    output logic live
);
    logic failed_q;

    // Sticky failure latch, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) failed_q <= 1'b0;
        else if (mis) failed_q <= 1'b1;
    end

    // Trusted status: not failed before, and not failing now.
    always_comb begin
        ok   = !failed_q;
        live = !failed_q && !mis;
    end

    // R4
    sticky_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ok |=> !ok);
    // R4
    mis_excludes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mis |=> !ok);
endmodule

// File: rtl/dlc_xcheck.sv
// Cross-channel comparator for lock-step operation. A disagreement is a
// mismatch of the valid bits, or equal valid bits with different data.
// Data is ignored when neither channel is valid.
module dlc_xcheck #(
    parameter int DW = 16
) (
    input  logic          a_vld,
    input  logic [DW-1:0] a_dat,
    input  logic          b_vld,
    input  logic [DW-1:0] b_dat,
    output logic          differ
);
    // Compare handshake and payload of the two channels.
    always_comb begin
        differ = (a_vld != b_vld) || (a_vld && (a_dat != b_dat));
    end
endmodule

// File: rtl/dlc_mode_reg.sv
// Mode register. It loads the requested mode during reset, and afterwards
// only in a cycle where neither channel presents a result.
module dlc_mode_reg
    import dlc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_sel,
    input  logic      busy,
    output run_mode_e mode_q
);
    // Capture mode in reset or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) mode_q <= run_mode_e'(mode_sel);
    end

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_q));
endmodule

// File: rtl/dlc_steer.sv
// Commit and steering stage. From the current mode, the channels' live
// status and the cross-check result, it decides what each output port
// commits, and registers the outcome. Ports without a commit carry zero data.
// Assumes live and differ are computed from the same cycle's inputs.
module dlc_steer
    import dlc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  run_mode_e      mode,
    input  logic [NCH-1:0] live,
    input  logic [NCH-1:0] vld,
    input  logic [DW-1:0]  a_dat,
    input  logic [DW-1:0]  b_dat,
    input  logic           differ,
    output logic           p0_vld,
    output logic [DW-1:0]  p0_dat,
    output logic           p1_vld,
    output logic [DW-1:0]  p1_dat,
    output logic           xdis,
    output logic           src_b
);
    logic          n0_vld, n1_vld, n_xdis, n_srcb;
    logic [DW-1:0] n0_dat, n1_dat;

    // Select what each port commits this cycle.
    always_comb begin
        n0_vld = 1'b0;
        n0_dat = '0;
        n1_vld = 1'b0;
        n1_dat = '0;
        n_xdis = 1'b0;
        n_srcb = 1'b0;
        if (mode == MODE_LOCK) begin
            if (live[0] && live[1]) begin
                n_xdis = differ;
                n0_vld = vld[0] && !differ;
                n0_dat = n0_vld ? a_dat : '0;
            end else if (live[0]) begin
                n0_vld = vld[0];
                n0_dat = vld[0] ? a_dat : '0;
            end else if (live[1]) begin
                n_srcb = 1'b1;
                n0_vld = vld[1];
                n0_dat = vld[1] ? b_dat : '0;
            end
        end else begin
            n0_vld = live[0] && vld[0];
            n0_dat = n0_vld ? a_dat : '0;
            n1_vld = live[1] && vld[1];
            n1_dat = n1_vld ? b_dat : '0;
        end
    end

    // Register the port outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p0_vld <= 1'b0;
            p0_dat <= '0;
            p1_vld <= 1'b0;
            p1_dat <= '0;
            xdis   <= 1'b0;
            src_b  <= 1'b0;
        end else begin
            p0_vld <= n0_vld;
            p0_dat <= n0_dat;
            p1_vld <= n1_vld;
            p1_dat <= n1_dat;
            xdis   <= n_xdis;
            src_b  <= n_srcb;
        end
    end

    // R2
    lock_port1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOCK) |=> !p1_vld);
    // R3
    disagree_withholds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xdis |-> (!p0_vld && !p1_vld));
    // R5
    failover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOCK && !live[0] && live[1] && vld[1]) |=> (p0_vld && src_b));
    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!p0_vld |-> p0_dat == '0) and (!p1_vld |-> p1_dat == '0));
endmodule

// File: rtl/duo_lockstep_ctrl.sv
// Top of the dual lock-step channel mode controller. It ties together the
// per-channel health trackers, the cross-channel comparator, the mode
// register and the commit stage, and derives the fatal flag.
// Assumes each channel's mismatch flag comes from that channel's own
// master/checker comparator, aligned with its result.
module duo_lockstep_ctrl
    import dlc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          a_vld,
    input  logic [DW-1:0] a_dat,
    input  logic          a_mis,
    input  logic          b_vld,
    input  logic [DW-1:0] b_dat,
    input  logic          b_mis,
    output logic          p0_vld,
    output logic [DW-1:0] p0_dat,
    output logic          p1_vld,
    output logic [DW-1:0] p1_dat,
    output logic          xdis,
    output logic          src_b,
    output logic [1:0]    ch_ok,
    output logic          fatal,
    output logic          mode_now
);
    logic [NCH-1:0] mis_v, ok_v, live_v, vld_v;
    logic           differ;
    run_mode_e      mode_q;

    // Gather the per-channel signals into vectors.
    always_comb begin
        mis_v = {b_mis, a_mis};
        vld_v = {b_vld, a_vld};
    end

    for (genvar g = 0; g < NCH; g++) begin : g_hlth
        dlc_health u_hlth (
            .clk  (clk),
            .rst_n(rst_n),
            .mis  (mis_v[g]),
            .ok   (ok_v[g]),
            .live (live_v[g])
        );
    end

    dlc_xcheck #(.DW(DW)) u_xchk (
        .a_vld (a_vld),
        .a_dat (a_dat),
        .b_vld (b_vld),
        .b_dat (b_dat),
        .differ(differ)
    );

    dlc_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_sel(mode_sel),
        .busy    (a_vld || b_vld),
        .mode_q  (mode_q)
    );

    dlc_steer #(.DW(DW)) u_steer (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_q),
        .live  (live_v),
        .vld   (vld_v),
        .a_dat (a_dat),
        .b_dat (b_dat),
        .differ(differ),
        .p0_vld(p0_vld),
        .p0_dat(p0_dat),
        .p1_vld(p1_vld),
        .p1_dat(p1_dat),
        .xdis  (xdis),
        .src_b (src_b)
    );

    // Drive the status outputs.
    always_comb begin
        ch_ok    = ok_v;
        fatal    = !ok_v[0] && !ok_v[1];
        mode_now = mode_q;
    end

    // R8
    fatal_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |-> (!p0_vld && !p1_vld && !xdis));
endmodule

// File: tb/sim_duo_lockstep_ctrl.sv
`timescale 1ns/1ps
// Bench: exhaustive sweeps of a 4-bit configuration in both modes, followed
// by directed fault injection. A bench-side model, written from the
// requirements, supplies the expected values.
module sim_duo_lockstep_ctrl;
    localparam int DW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sel = 1'b0;
    logic a_vld = 1'b0, a_mis = 1'b0, b_vld = 1'b0, b_mis = 1'b0;
    logic [DW-1:0] a_dat = '0, b_dat = '0;
    logic p0_vld, p1_vld, xdis, src_b, fatal, mode_now;
    logic [DW-1:0] p0_dat, p1_dat;
    logic [1:0] ch_ok;

    int n_chk = 0;
    int n_fail = 0;
    bit m_fa, m_fb, m_mode;

    always #2.5 clk = ~clk;

    duo_lockstep_ctrl #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .a_vld(a_vld), .a_dat(a_dat), .a_mis(a_mis),
        .b_vld(b_vld), .b_dat(b_dat), .b_mis(b_mis),
        .p0_vld(p0_vld), .p0_dat(p0_dat), .p1_vld(p1_vld), .p1_dat(p1_dat),
        .xdis(xdis), .src_b(src_b), .ch_ok(ch_ok), .fatal(fatal),
        .mode_now(mode_now)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(input bit m);
        rst_n = 1'b0; mode_sel = m;
        a_vld = 0; b_vld = 0; a_mis = 0; b_mis = 0; a_dat = '0; b_dat = '0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        m_fa = 0; m_fb = 0; m_mode = m;
        // R1: state right after reset
        chk("R1", "p0_vld", p0_vld, 0);
        chk("R1", "p1_vld", p1_vld, 0);
        chk("R1", "xdis", xdis, 0);
        chk("R1", "src_b", src_b, 0);
        chk("R1", "ch_ok", ch_ok, 3);
        chk("R1", "fatal", fatal, 0);
        chk("R1", "mode_now", mode_now, m);
    endtask

    task automatic step(input bit m, input bit av, input int ad, input bit am,
                        input bit bv, input int bd, input bit bm);
        bit ha, hb, diff, e0v, e1v, ex, es;
        int e0d, e1d;
        string tg;
        mode_sel = m; a_vld = av; a_dat = ad[DW-1:0]; a_mis = am;
        b_vld = bv; b_dat = bd[DW-1:0]; b_mis = bm;
        ha = !m_fa && !am; hb = !m_fb && !bm;
        e0v = 0; e1v = 0; e0d = 0; e1d = 0; ex = 0; es = 0;
        if (m_mode == 1'b0) begin
            diff = (av != bv) || (av && (ad[DW-1:0] != bd[DW-1:0]));
            if (ha && hb) begin
                ex = diff; e0v = av && !diff; tg = diff ? "R3" : "R2";
            end else if (ha) begin
                e0v = av; tg = "R5";
            end else if (hb) begin
                e0v = bv; es = 1; tg = "R5";
            end else tg = "R8";
            e0d = e0v ? (es ? bd : ad) : 0;
        end else begin
            e0v = ha && av; e1v = hb && bv;
            e0d = e0v ? ad : 0; e1d = e1v ? bd : 0;
            tg = (!ha && !hb) ? "R8" : (!ha || !hb) ? "R7" : "R6";
        end
        m_fa = m_fa || am; m_fb = m_fb || bm;
        if (!av && !bv) m_mode = m;
        @(posedge clk);
        #1;
        chk(tg, "p0_vld", p0_vld, e0v);
        chk(tg, "p0_dat (R10 zero when idle)", p0_dat, e0d);
        chk(tg, "p1_vld", p1_vld, e1v);
        chk(tg, "p1_dat (R10 zero when idle)", p1_dat, e1d);
        chk(tg, "xdis", xdis, ex);
        chk(tg, "src_b", src_b, es);
        chk("R4", "ch_ok", ch_ok, {!m_fb, !m_fa});
        chk("R8", "fatal", fatal, m_fa && m_fb);
        chk("R9", "mode_now", mode_now, m_mode);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        // R2 R3: lock-step sweep of all valid pairs and data pairs
        for (int v = 0; v < 4; v++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    step(0, v[0], x, 0, v[1], y, 0);
        // R9: request during traffic is held, then taken when idle
        step(1, 1, 3, 0, 1, 3, 0);
        step(1, 0, 0, 0, 1, 2, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        // R6: parallel sweep
        for (int v = 0; v < 4; v++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    step(1, v[0], x, 0, v[1], y, 0);
        // R7: A fails mid-traffic in parallel mode, B continues
        step(1, 1, 5, 1, 1, 9, 0);
        for (int i = 0; i < 6; i++) step(1, 1, i, 0, 1, 15 - i, 0);
        // R8: B fails as well
        step(1, 1, 7, 0, 1, 7, 1);
        step(1, 1, 7, 0, 1, 7, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 1, 4, 0, 1, 4, 0);
        // R1: reset into parallel mode, then back into lock-step
        do_reset(1'b1);
        step(1, 1, 6, 0, 1, 2, 0);
        do_reset(1'b0);
        // R5: A fails in lock-step, B takes over in the same cycle
        step(0, 1, 3, 0, 1, 3, 0);
        step(0, 1, 3, 1, 1, 12, 0);
        for (int i = 0; i < 8; i++) step(0, i[0], i, 0, 1, i + 8, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        // R8: B fails too
        step(0, 1, 1, 0, 1, 1, 1);
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 1, 2, 0, 1, 2, 0);
        // R8: both fail in the same cycle in lock-step
        do_reset(1'b0);
        step(0, 1, 9, 1, 1, 9, 1);
        step(0, 1, 9, 0, 1, 9, 0);
        // R5: only B fails, A keeps port 0 without cross-check
        do_reset(1'b0);
        step(0, 1, 10, 0, 1, 11, 1);
        for (int i = 0; i < 4; i++) step(0, 1, i, 0, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule